// File: doc/BRIEF.md
# SPI Identification Responder

This block is the target-side logic of an SPI identification read. A host lowers chip select and clocks in one opcode byte. When that byte is the identification opcode, the block shifts back a fixed four-byte reply: a manufacturer code, two device code bytes and a trailing length byte of 00h, which says that no extended information follows. Any other opcode is ignored. The serial output stays undriven for the rest of that frame.

The three serial inputs (chip select, serial clock and host data) are oversampled by the block's own system clock through a short synchronizer. Edges of the serial clock are then detected in that clock domain. Opcode bits are taken on rising serial-clock edges, and reply bits are launched on falling serial-clock edges, most significant bit first. The output enable models the high-impedance state of the reply pin. It is low whenever chip select is high, and it drops as soon as chip select rises, even in the middle of a byte. Both clock polarities are accepted: serial clock idling low (mode 0) and idling high (mode 3).

Top module: `spi_id_responder`

## Requirements
- R1: Out of reset, and whenever the output enable is low, the reply output reads 0 and the output enable is 0.
- R2: A frame begins on a falling chip-select edge. The next eight rising serial-clock edges capture the opcode, most significant bit first, from the host data input.
- R3: When the opcode equals OPCODE (default 9Fh), each later falling serial-clock edge presents the next reply bit, MSB first. The bits form the 32-bit word {MFR_ID, DEV_ID_HI, DEV_ID_LO, 8'h00}, with MFR_ID first on the wire.
- R4: After all 32 reply bits, further falling edges in the same frame drive 0 while the output enable stays high.
- R5: A rising chip-select edge at any bit position ends the frame. The output enable and the reply output return to 0 within SYNC_STAGES+1 clock cycles, and the next frame starts again from the opcode.
- R6: When the captured opcode differs from OPCODE, the output enable stays 0 until chip select rises.
- R7: Serial-clock and host-data activity while chip select is high has no effect. The output enable stays 0, and the next frame decodes and replies normally.
- R8: The block works with the serial clock idling low or idling high when chip select falls. In the idle-high case, the first falling edge after chip select falls is not taken as an opcode bit.
- R9: A serial-clock or chip-select transition that is first sampled on a clock edge is reflected on the outputs exactly SYNC_STAGES clock cycles after that edge.
- R10: The output enable stays 0 from the start of the frame until the first falling serial-clock edge after the eighth opcode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial interface |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Chip select from the host, active low |
| sclk_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Host data, sampled on rising serial-clock edges |
| miso_o | output | 1 | Reply data, updated on falling serial-clock edges; 0 when not enabled |
| miso_oe_o | output | 1 | Output enable for the reply pin; low means high impedance |

## Verification
The bench checks several cases against a cycle-by-cycle model:
- Frames cut off mid-byte. A design that missed the abort would keep driving the pin after deselect.
- Reads that run past the fourth byte. A design that recirculated the reply would repeat the manufacturer code instead of zeros.
- Frames started with the serial clock idling high. A design that counted that first falling edge would read a shifted opcode.
- A near-miss opcode, and clock and data traffic while deselected. A design that leaked either would switch on its output or carry a stale partial opcode into the next frame.
- Every bit, timed against the model. This catches a reply launched one edge early or late, or a latency that differs from the synchronizer depth.

// File: rtl/idr_pkg.sv
package idr_pkg;

    // Frame phase of the responder
    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,
        FR_OPCODE = 2'd1,
        FR_REPLY  = 2'd2,
        FR_MUTE   = 2'd3
    } frame_e;

    typedef struct packed {
        frame_e st;
    } frame_t;

    // Bit positions inside the synchronized input vector
    localparam int unsigned PIN_CS   = 0;
    localparam int unsigned PIN_SCK  = 1;
    localparam int unsigned PIN_MOSI = 2;
    localparam int unsigned PIN_CNT  = 3;

endpackage

// File: rtl/idr_sync.sv
module idr_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 3,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]             prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d = sy_q;
        sy_d.chain[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            sy_d.chain[i] = sy_q.chain[i-1];
        end
        sy_d.prev = sy_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sy_q.chain <= {STAGES{INIT}};
            sy_q.prev  <= INIT;
        end else begin
            sy_q <= sy_d;
        end
    end

    // Edge detection per pin
    for (genvar g = 0; g < int'(WIDTH); g++) begin : g_edge
        assign lvl_o[g]  = sy_q.chain[STAGES-1][g];
        assign rise_o[g] = sy_q.chain[STAGES-1][g] & ~sy_q.prev[g];
        assign fall_o[g] = ~sy_q.chain[STAGES-1][g] & sy_q.prev[g];
    end

endmodule

// File: rtl/idr_opcode_rx.sv
module idr_opcode_rx #(
    parameter int unsigned OPC_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             sample_i,
    input  logic             bit_i,
    output logic             done_o,
    output logic [OPC_W-1:0] code_o
);

    localparam int unsigned CNT_W = $clog2(OPC_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OPC_W - 1);

    typedef struct packed {
        logic [OPC_W-1:0] sh;
        logic [CNT_W-1:0] cnt;
    } rx_t;

    rx_t rx_d, rx_q;
    logic [OPC_W-1:0] shifted;

    assign shifted = {rx_q.sh[OPC_W-2:0], bit_i};
    assign code_o  = shifted;
    assign done_o  = sample_i && (rx_q.cnt == LAST);

    always_comb begin
        rx_d = rx_q;
        if (start_i) begin
            rx_d.sh  = '0;
            rx_d.cnt = '0;
        end else if (sample_i) begin
            rx_d.sh = shifted;
            if (rx_q.cnt != LAST) begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

endmodule

// File: rtl/idr_reply_tx.sv
module idr_reply_tx #(
    parameter int unsigned REPLY_W = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               clear_i,
    input  logic               load_i,
    input  logic [REPLY_W-1:0] word_i,
    input  logic               shift_i,
    output logic               so_o,
    output logic               oe_o
);

    typedef struct packed {
        logic [REPLY_W-1:0] sh;
        logic               so;
        logic               oe;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (clear_i) begin
            tx_d.sh = '0;
            tx_d.so = 1'b0;
            tx_d.oe = 1'b0;
        end else if (load_i) begin
            tx_d.sh = word_i;
        end else if (shift_i) begin
            // zero fill: once the word is exhausted the pin keeps driving 0
            tx_d.so = tx_q.sh[REPLY_W-1];
            tx_d.sh = {tx_q.sh[REPLY_W-2:0], 1'b0};
            tx_d.oe = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign so_o = tx_q.so;
    assign oe_o = tx_q.oe;

endmodule

// File: rtl/spi_id_responder.sv
module spi_id_responder
    import idr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned OPC_W       = 8,
    parameter logic [OPC_W-1:0] OPCODE = 8'h9F,
    parameter logic [7:0] MFR_ID       = 8'h1F,
    parameter logic [7:0] DEV_ID_HI    = 8'h25,
    parameter logic [7:0] DEV_ID_LO    = 8'h00
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic csn_i,
    input  logic sclk_i,
    input  logic mosi_i,
    output logic miso_o,
    output logic miso_oe_o
);

    localparam logic [7:0] EXT_LEN = 8'h00;
    localparam int unsigned REPLY_W = 32;
    localparam logic [REPLY_W-1:0] REPLY_WORD = {MFR_ID, DEV_ID_HI, DEV_ID_LO, EXT_LEN};
    localparam logic [PIN_CNT-1:0] PIN_INIT = PIN_CNT'(1) << PIN_CS;

    logic [PIN_CNT-1:0] pin_lvl, pin_rise, pin_fall;
    logic cs_lvl, cs_fall, sck_rise, sck_fall, mosi_lvl;
    logic rx_sample, rx_done, id_hit;
    logic [OPC_W-1:0] rx_code;
    logic tx_clear, tx_load, tx_shift;

    frame_t fr_d, fr_q;

    idr_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (PIN_CNT),
        .INIT   (PIN_INIT)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({mosi_i, sclk_i, csn_i}),
        .lvl_o   (pin_lvl),
        .rise_o  (pin_rise),
        .fall_o  (pin_fall)
    );

    assign cs_lvl   = pin_lvl[PIN_CS];
    assign cs_fall  = pin_fall[PIN_CS];
    assign sck_rise = pin_rise[PIN_SCK];
    assign sck_fall = pin_fall[PIN_SCK];
    assign mosi_lvl = pin_lvl[PIN_MOSI];

    assign rx_sample = (fr_q.st == FR_OPCODE) && sck_rise && !cs_lvl && !cs_fall;

    idr_opcode_rx #(
        .OPC_W (OPC_W)
    ) u_rx (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (cs_fall),
        .sample_i (rx_sample),
        .bit_i    (mosi_lvl),
        .done_o   (rx_done),
        .code_o   (rx_code)
    );

    assign id_hit   = rx_done && (rx_code == OPCODE);
    assign tx_clear = cs_lvl || cs_fall;
    assign tx_load  = id_hit;
    assign tx_shift = (fr_q.st == FR_REPLY) && sck_fall;

    always_comb begin
        fr_d = fr_q;
        if (cs_lvl) begin
            fr_d.st = FR_IDLE;
        end else if (cs_fall) begin
            fr_d.st = FR_OPCODE;
        end else if (rx_done) begin
            fr_d.st = id_hit ? FR_REPLY : FR_MUTE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fr_q.st <= FR_IDLE;
        end else begin
            fr_q <= fr_d;
        end
    end

    idr_reply_tx #(
        .REPLY_W (REPLY_W)
    ) u_tx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (tx_clear),
        .load_i  (tx_load),
        .word_i  (REPLY_WORD),
        .shift_i (tx_shift),
        .so_o    (miso_o),
        .oe_o    (miso_oe_o)
    );

endmodule

// File: rtl/idr_checker.sv
module idr_checker #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic clk_i,
    input logic rst_ni,
    input logic csn_i,
    input logic miso_o,
    input logic miso_oe_o,
    input logic sck_fall
);

    logic [7:0] cs_hi_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cs_hi_q <= '0;
        end else if (!csn_i) begin
            cs_hi_q <= '0;
        end else if (cs_hi_q != 8'hFF) begin
            cs_hi_q <= cs_hi_q + 8'd1;
        end
    end

    // R1: an undriven pin carries 0
    assert_quiet_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !miso_oe_o |-> !miso_o);

    // R3: the reply bit only moves after a detected falling clock edge
    assert_bit_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (miso_oe_o && $past(miso_oe_o) && (miso_o != $past(miso_o))) |-> $past(sck_fall));

    // R10: driving begins only on a falling clock edge
    assert_enable_on_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(miso_oe_o) |-> $past(sck_fall));

    // R5: deselect releases the pin within the synchronizer latency
    assert_release_on_deselect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_hi_q >= 8'(SYNC_STAGES + 1)) |-> !miso_oe_o);

endmodule

bind spi_id_responder idr_checker #(
    .SYNC_STAGES (SYNC_STAGES)
) u_idr_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .csn_i     (csn_i),
    .miso_o    (miso_o),
    .miso_oe_o (miso_oe_o),
    .sck_fall  (sck_fall)
);

// File: tb/sim_spi_id_responder.sv
`timescale 1ns/1ps
module sim_spi_id_responder;

    localparam int STAGES = 2;
    localparam int HALF   = 4;
    localparam logic [7:0] ID_OP  = 8'h9F;
    localparam logic [7:0] M_ID   = 8'hC3;
    localparam logic [7:0] D_HI   = 8'h26;
    localparam logic [7:0] D_LO   = 8'h1B;
    localparam logic [31:0] WORD  = {M_ID, D_HI, D_LO, 8'h00};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic so, oe;

    always #2 clk = ~clk;

    spi_id_responder #(
        .SYNC_STAGES (STAGES),
        .MFR_ID      (M_ID),
        .DEV_ID_HI   (D_HI),
        .DEV_ID_LO   (D_LO)
    ) u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .csn_i     (cs_n),
        .sclk_i    (sck),
        .mosi_i    (si),
        .miso_o    (so),
        .miso_oe_o (oe)
    );

    int runs = 0, fails = 0;
    bit finished = 0;

    // behavioural reference
    int m_phase = 0;   // 0 idle, 1 opcode, 2 reply, 3 muted
    int m_bits = 0;
    logic [7:0]  m_op = '0;
    logic [31:0] m_sh = '0;
    logic m_oe = 0, m_so = 0, m_pcs = 1, m_psck = 0;
    logic [1:0] expq[$];

    logic obs_so = 0, obs_oe = 0;
    bit saw_oe = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        runs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_step(input logic c, input logic k, input logic d);
        if (c) begin
            m_phase = 0; m_oe = 0; m_so = 0;
        end else if (m_pcs) begin
            m_phase = 1; m_bits = 0; m_op = '0; m_oe = 0; m_so = 0;
        end else if (m_phase == 1 && !m_psck && k) begin
            m_op = {m_op[6:0], d};
            m_bits++;
            if (m_bits == 8) begin
                if (m_op == ID_OP) begin
                    m_phase = 2; m_sh = WORD;
                end else begin
                    m_phase = 3;
                end
            end
        end else if (m_phase == 2 && m_psck && !k) begin
            m_oe = 1; m_so = m_sh[31]; m_sh = m_sh << 1;
        end
        m_pcs = c; m_psck = k;
    endtask

    // one clock step: compare, advance model, then inputs may change
    task automatic tick();
        logic [1:0] e;
        @(negedge clk);
        obs_so = so; obs_oe = oe;
        if (oe) saw_oe = 1;
        e = expq.pop_front();
        chk({oe, so} === e, "R9 cycle model", {62'd0, oe, so}, {62'd0, e});
        model_step(cs_n, sck, si);
        expq.push_back({m_oe, m_so});
    endtask

    task automatic hold(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // full frame; returns the bits the host sampled before each rising edge
    task automatic frame(input logic [7:0] op, input int nbits, input bit m3,
                         output logic [63:0] got, output bit oe_pre);
        got = '0;
        sck = m3; hold(HALF);
        cs_n = 0; hold(HALF);
        for (int b = 7; b >= 0; b--) begin
            sck = 0; si = op[b]; hold(HALF);
            sck = 1; hold(HALF);
        end
        oe_pre = obs_oe;
        for (int b = 0; b < nbits; b++) begin
            sck = 0; hold(HALF);
            got = {got[62:0], obs_so};
            sck = 1; hold(HALF);
        end
        if (!m3) begin
            sck = 0; hold(HALF);
        end
        cs_n = 1; hold(2 * HALF);
    endtask

    function automatic logic [63:0] expect_bits(input int n);
        logic [63:0] r = '0;
        for (int i = 0; i < n; i++) r = {r[62:0], (i < 32) ? WORD[31-i] : 1'b0};
        return r;
    endfunction

    initial begin
        logic [63:0] got;
        bit pre;
        for (int i = 0; i < STAGES; i++) expq.push_back(2'b00);
        repeat (4) @(negedge clk);
        rst_n = 1;
        tick();
        chk(obs_oe == 0 && obs_so == 0, "R1 reset state", {62'd0, obs_oe, obs_so}, 64'd0);

        // R2 R3 mode 0 full reply
        saw_oe = 0;
        frame(ID_OP, 32, 1'b0, got, pre);
        chk(got == expect_bits(32), "R3 reply mode 0", got, expect_bits(32));
        chk(pre == 0, "R10 enable low before first fall", {63'd0, pre}, 64'd0);
        chk(saw_oe == 1, "R2 opcode recognised", {63'd0, saw_oe}, 64'd1);
        chk(obs_oe == 0 && obs_so == 0, "R5 released after frame", {62'd0, obs_oe, obs_so}, 64'd0);

        // R8 mode 3
        frame(ID_OP, 32, 1'b1, got, pre);
        chk(got == expect_bits(32), "R8 reply mode 3", got, expect_bits(32));
        chk(pre == 0, "R10 mode 3 enable low", {63'd0, pre}, 64'd0);

        // R4 read past the end
        frame(ID_OP, 48, 1'b0, got, pre);
        chk(got == expect_bits(48), "R4 zeros after length byte", got, expect_bits(48));

        // R5 abort mid-byte, then a fresh frame
        frame(ID_OP, 13, 1'b0, got, pre);
        chk(got == expect_bits(13), "R5 partial reply", got, expect_bits(13));
        chk(obs_oe == 0 && obs_so == 0, "R5 released mid-byte", {62'd0, obs_oe, obs_so}, 64'd0);
        frame(ID_OP, 32, 1'b1, got, pre);
        chk(got == expect_bits(32), "R5 next frame after abort", got, expect_bits(32));

        // R5 abort inside the opcode
        sck = 0; cs_n = 0; hold(HALF);
        for (int b = 7; b >= 4; b--) begin
            sck = 0; si = ID_OP[b]; hold(HALF);
            sck = 1; hold(HALF);
        end
        cs_n = 1; hold(2 * HALF);
        frame(ID_OP, 24, 1'b0, got, pre);
        chk(got == expect_bits(24), "R5 restart after opcode abort", got, expect_bits(24));

        // R6 near-miss opcode
        saw_oe = 0;
        frame(8'h9E, 32, 1'b0, got, pre);
        chk(saw_oe == 0, "R6 other opcode stays silent", {63'd0, saw_oe}, 64'd0);
        saw_oe = 0;
        frame(8'h1F, 16, 1'b1, got, pre);
        chk(saw_oe == 0, "R6 other opcode mode 3", {63'd0, saw_oe}, 64'd0);

        // R7 traffic while deselected
        saw_oe = 0;
        cs_n = 1;
        for (int i = 0; i < 16; i++) begin
            si = ID_OP[i % 8]; sck = ~sck; hold(HALF);
        end
        sck = 0; hold(HALF);
        chk(saw_oe == 0, "R7 deselected traffic ignored", {63'd0, saw_oe}, 64'd0);
        frame(ID_OP, 32, 1'b0, got, pre);
        chk(got == expect_bits(32), "R7 frame after idle traffic", got, expect_bits(32));

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            runs++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

endmodule